// File: doc/BRIEF.md
# Root Port Error Status and Interrupt Collector

This block sits at a root port and collects error messages arriving from below it. Each message carries a class (correctable, non-fatal or fatal) and a 16-bit source ID. The block keeps a root error status register with received, multiple-received and first-fatal flags. It also keeps two source ID fields, one for the first correctable error and one for the first uncorrectable error. Software reaches the command, status and source registers through a small word-wide register port. The status flags are write-one-to-clear.

An interrupt condition exists when any class that has been received also has its enable set in the command register. A strap selects how this condition is signalled. In level mode, a wire follows the condition. In message mode, the block emits a one-cycle request that carries a 5-bit vector number, and it does so only when the condition goes from false to true. A device-specific input supplies that vector number, and the number also appears read-only in the upper bits of the status register.

Top module: `root_err_collector`

## Requirements
- R1: A correctable message (class code 0) sets status bit 0. If bit 0 was already set before the message, the message sets bit 1 (multiple correctable) instead of recording its source. Otherwise its source ID is stored in bits 15:0 of the source register (address 2).
- R2: A non-fatal (class 1) or fatal (class 2) message sets status bit 2. If bit 2 was already set before the message, the message sets bit 3 (multiple uncorrectable) instead of recording its source. Otherwise its source ID is stored in bits 31:16 of the source register.
- R3: A non-fatal message sets status bit 5, and a fatal message sets status bit 6.
- R4: A fatal message sets status bit 4 (first fatal) only when status bit 2 was clear before that message.
- R5: Status lives at address 1. Writing a 1 to any of bits 6:0 clears that bit. A message that arrives in the same cycle still sets its bits, and it takes its multiple and first-fatal decisions from the status as it stood before the write. Bits 31:27 read the vector input, and writes to them have no effect.
- R6: The command register sits at address 0. Bit 0 enables correctable errors, bit 1 enables non-fatal errors and bit 2 enables fatal errors. It is read/write, and reset clears it.
- R7: In message mode, a one-cycle pulse appears on msi_req in the cycle after the clock edge at which the condition, OR over classes of (enable AND received bit), turns from false to true. The condition can rise because a message arrives or because a command write is made. During that pulse, msi_vec shows the vector input as it was sampled at that edge.
- R8: In level mode, irq_level equals the condition built from the current registers and msi_req stays low. In message mode, irq_level stays low.
- R9: The source register is read-only, so writes to address 2 change nothing. Messages with class code 3 are ignored.
- R10: After reset, the command, status and source registers read zero and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msi_mode | input | 1 | Strap: 1 selects edge message signalling, 0 selects level |
| vec_num | input | 5 | Device-specific interrupt vector number |
| msg_valid | input | 1 | Error message present this cycle |
| msg_class | input | 2 | 0 correctable, 1 non-fatal, 2 fatal, 3 ignored |
| msg_src | input | 16 | Source ID of the message |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 source |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_level | output | 1 | Level interrupt |
| msi_req | output | 1 | One-cycle message interrupt request |
| msi_vec | output | 5 | Vector carried with msi_req |

## Verification
The most telling symptom of a wrong first/multiple decision is a source field that changes when it should hold, or a multiple flag that appears one message too early. Either one shows on the next register read after the offending message. A condition register that is stale or wrongly mapped shows at once. In level mode it flips irq_level in the very cycle the registers change. In message mode it produces a missing, doubled or spurious msi_req one cycle after the edge. The bench compares every register and both interrupt outputs after every cycle, under random messages interleaved with random writes, so any such divergence is caught within one cycle.

// File: rtl/root_err_collector.sv
module root_err_collector #(
  parameter int SRC_W  = 16,
  parameter int VEC_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_mode,
  input  logic [VEC_W-1:0]  vec_num,
  input  logic              msg_valid,
  input  logic [1:0]        msg_class,
  input  logic [SRC_W-1:0]  msg_src,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_level,
  output logic              msi_req,
  output logic [VEC_W-1:0]  msi_vec
);
  localparam int ST_W = 7;
  localparam int B_COR = 0, B_MCOR = 1, B_UNC = 2, B_MUNC = 3, B_FF = 4, B_NF = 5, B_FAT = 6;

  logic [2:0]      cmd_q, cmd_d;
  logic [ST_W-1:0] st_q, st_d;
  logic [SRC_W-1:0] src_cor_q, src_unc_q;
  logic            msi_q;
  logic [VEC_W-1:0] vec_q;

  wire is_cor = msg_valid && (msg_class == 2'd0);
  wire is_nf  = msg_valid && (msg_class == 2'd1);
  wire is_fat = msg_valid && (msg_class == 2'd2);
  wire is_unc = is_nf || is_fat;
  wire wr_cmd = reg_wr && (reg_addr == 2'd0);
  wire wr_st  = reg_wr && (reg_addr == 2'd1);

  always_comb begin
    st_d = st_q & ~(wr_st ? reg_wdata[ST_W-1:0] : '0);
    if (is_cor) begin
      if (st_q[B_COR]) st_d[B_MCOR] = 1'b1;
      st_d[B_COR] = 1'b1;
    end
    if (is_unc) begin
      if (st_q[B_UNC]) st_d[B_MUNC] = 1'b1;
      st_d[B_UNC] = 1'b1;
    end
    if (is_nf) st_d[B_NF] = 1'b1;
    if (is_fat) begin
      st_d[B_FAT] = 1'b1;
      if (!st_q[B_UNC]) st_d[B_FF] = 1'b1;
    end
    cmd_d = wr_cmd ? reg_wdata[2:0] : cmd_q;
  end

  wire [2:0] cls_now  = {st_q[B_FAT], st_q[B_NF], st_q[B_COR]};
  wire [2:0] cls_next = {st_d[B_FAT], st_d[B_NF], st_d[B_COR]};
  wire cond_now  = |(cmd_q & cls_now);
  wire cond_next = |(cmd_d & cls_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      st_q      <= '0;
      src_cor_q <= '0;
      src_unc_q <= '0;
      msi_q     <= 1'b0;
      vec_q     <= '0;
    end else begin
      cmd_q <= cmd_d;
      st_q  <= st_d;
      if (is_cor && !st_q[B_COR]) src_cor_q <= msg_src;
      if (is_unc && !st_q[B_UNC]) src_unc_q <= msg_src;
      msi_q <= msi_mode && cond_next && !cond_now;
      vec_q <= vec_num;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[2:0] = cmd_q;
      2'd1: begin
        reg_rdata[ST_W-1:0] = st_q;
        reg_rdata[DATA_W-1 -: VEC_W] = vec_num;
      end
      2'd2: begin
        reg_rdata[SRC_W-1:0]     = src_cor_q;
        reg_rdata[SRC_W +: SRC_W] = src_unc_q;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq_level = !msi_mode && cond_now;
  assign msi_req   = msi_q;
  assign msi_vec   = vec_q;

  AST_MULTI_COR_NEEDS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[B_MCOR]) |-> $past(st_q[B_COR])); // R1
  AST_COR_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q[B_COR]) && st_q[B_COR]) |-> $stable(src_cor_q)); // R1
  AST_UNC_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q[B_UNC]) && st_q[B_UNC]) |-> $stable(src_unc_q)); // R2
  AST_FIRST_FATAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[B_FF]) |-> !$past(st_q[B_UNC])); // R4
  AST_MSI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |=> !msi_req); // R7
  AST_MSI_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $past(msi_mode)); // R8
endmodule

// File: tb/tb_root_err_collector.sv
module tb_root_err_collector;
  logic clk = 0, rst_n = 0, msi_mode = 0;
  logic [4:0] vec_num = 0;
  logic msg_valid = 0;
  logic [1:0] msg_class = 0;
  logic [15:0] msg_src = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq_level, msi_req;
  logic [4:0] msi_vec;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [2:0] m_cmd;
  logic [6:0] m_st;
  logic [15:0] m_scor, m_sunc;
  logic m_msi;
  logic [4:0] m_vec;

  root_err_collector dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic cond(input logic [2:0] c, input logic [6:0] s);
    return |(c & {s[6], s[5], s[0]});
  endfunction

  task automatic model_reset();
    m_cmd = 0; m_st = 0; m_scor = 0; m_sunc = 0; m_msi = 0; m_vec = 0;
  endtask

  task automatic model_step();
    logic [6:0] s;
    logic [2:0] c;
    logic cor, unc, fat, nf;
    cor = msg_valid && msg_class == 0;
    nf  = msg_valid && msg_class == 1;
    fat = msg_valid && msg_class == 2;
    unc = nf || fat;
    s = m_st;
    if (reg_wr && reg_addr == 1) s = s & ~reg_wdata[6:0];
    if (cor) begin
      if (m_st[0]) s[1] = 1; else m_scor = msg_src;
      s[0] = 1;
    end
    if (unc) begin
      if (m_st[2]) s[3] = 1; else m_sunc = msg_src;
      s[2] = 1;
    end
    if (nf) s[5] = 1;
    if (fat) begin
      s[6] = 1;
      if (!m_st[2]) s[4] = 1;
    end
    c = (reg_wr && reg_addr == 0) ? reg_wdata[2:0] : m_cmd;
    m_msi = msi_mode && cond(c, s) && !cond(m_cmd, m_st);
    m_vec = vec_num;
    m_cmd = c; m_st = s;
  endtask

  task automatic compare_all();
    chk(msi_mode ? "R7 msi_req" : "R8 msi_req quiet", {31'b0, msi_req}, {31'b0, m_msi});
    if (m_msi) chk("R7 msi_vec", {27'b0, msi_vec}, {27'b0, m_vec});
    chk("R8 irq_level", {31'b0, irq_level}, {31'b0, !msi_mode && cond(m_cmd, m_st)});
    reg_addr = 0; #1 chk("R6 command", reg_rdata, {29'b0, m_cmd});
    reg_addr = 1; #1 chk("R5 status", reg_rdata, {vec_num, 20'b0, m_st});
    reg_addr = 2; #1 chk("R9 source", reg_rdata, {m_sunc, m_scor});
  endtask

  task automatic step(input logic v, input logic [1:0] cls, input logic [15:0] src,
                      input logic wr, input logic [1:0] a, input logic [31:0] wd);
    msg_valid = v; msg_class = cls; msg_src = src;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    msg_valid = 0; reg_wr = 0;
    compare_all();
  endtask

  task automatic do_reset();
    rst_n = 0;
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    vec_num = 5'd9;
    @(negedge clk);
    do_reset();
    chk("R10 reset irq", {30'b0, irq_level, msi_req}, 32'b0);

    // Directed, level mode
    step(1, 0, 16'hAAAA, 0, 0, 0);
    reg_addr = 2; #1 chk("R1 first cor source", reg_rdata[15:0], 16'hAAAA);
    step(1, 0, 16'hBBBB, 0, 0, 0);
    reg_addr = 1; #1 chk("R1 multi cor", reg_rdata[1:0], 2'b11);
    reg_addr = 2; #1 chk("R1 source held", reg_rdata[15:0], 16'hAAAA);
    step(1, 1, 16'h1111, 0, 0, 0);
    step(1, 2, 16'h2222, 0, 0, 0);
    reg_addr = 1; #1 chk("R4 no first fatal after nonfatal", {31'b0, reg_rdata[4]}, 0);
    chk("R3 nf and fatal bits", {30'b0, reg_rdata[6:5]}, 2'b11);
    chk("R2 multi uncor", {30'b0, reg_rdata[3:2]}, 2'b11);
    reg_addr = 2; #1 chk("R2 uncor source", reg_rdata[31:16], 16'h1111);
    step(0, 0, 0, 1, 2, 32'hFFFF_FFFF);
    reg_addr = 2; #1 chk("R9 source write ignored", reg_rdata, {16'h1111, 16'hAAAA});
    step(0, 0, 0, 1, 1, 32'hFFFF_FFFF);
    reg_addr = 1; #1 chk("R5 w1c all", reg_rdata, {5'd9, 27'b0});
    step(1, 3, 16'h3333, 0, 0, 0);
    reg_addr = 1; #1 chk("R9 class 3 ignored", reg_rdata[6:0], 0);
    step(1, 2, 16'h4444, 1, 1, 32'h7F);
    reg_addr = 1; #1 chk("R4 first fatal", {31'b0, reg_rdata[4]}, 1);
    step(0, 0, 0, 1, 0, 32'h4);
    chk("R8 level follows command", {31'b0, irq_level}, 1);

    // Directed, message mode
    msi_mode = 1;
    do_reset();
    step(1, 1, 16'h0005, 0, 0, 0);
    chk("R7 no msi while disabled", {31'b0, msi_req}, 0);
    vec_num = 5'd22;
    step(0, 0, 0, 1, 0, 32'h2);
    chk("R7 msi on command write", {31'b0, msi_req}, 1);
    chk("R7 msi vector", {27'b0, msi_vec}, 5'd22);
    step(1, 1, 16'h0006, 0, 0, 0);
    chk("R7 no msi when already true", {31'b0, msi_req}, 0);

    // Random phases
    for (int ph = 0; ph < 2; ph++) begin
      msi_mode = ph[0];
      do_reset();
      for (int i = 0; i < 3000; i++) begin
        logic [1:0] a;
        logic [31:0] wd;
        a = 2'($urandom_range(0, 3));
        wd = $urandom;
        if (($urandom % 4) != 0) wd[6:0] = 7'(1 << $urandom_range(0, 6));
        vec_num = 5'($urandom);
        step(($urandom % 2) == 0, 2'($urandom), 16'($urandom),
             ($urandom % 4) == 0, a, wd);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule